// File: doc/BRIEF.md
# Two-Level Interrupt Cascade Controller

This block folds seventeen serial interrupt lines into a single interrupt line for the upstream controller. It does this in two register levels. The first level, the host-controller stage, latches each asserted line into a sticky status register. It filters that register through a mask and gates the result with an enable bit. The masked result is a level signal, and it appears as one bit of the raw-input register of the second level. The second level, the bus-master stage, accumulates its masked input into its own sticky status register. The upstream interrupt is asserted while that status register holds any set bit.

Software reaches both levels over a simple single-cycle register bus with 32-bit data. Both status registers clear only the bits that software writes as 1. Interrupts are evaluated on every clock, so a new source event reaches the output without waiting for a register write. A register write likewise changes the output without waiting for a source event. The block also holds two plain storage registers and a polarity register. The polarity register is only stored: it has no effect on interrupt logic.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the read-size store at offset 0x28, which reads 0x02000000, and `irq_out` is low.
- R2: Offsets 0x24 (id-select store) and 0x28 (read-size store) read back the last full 32-bit value written to them.
- R3: While source line n (0..16) is high at a clock edge, bit (31 - n) of the first-level status (offset 0x38) is set after that edge. It stays set after the line falls.
- R4: A write to 0x38 clears exactly the status bits written as 1 and keeps the others. If a line is still high in the cycle of the write, its bit stays set.
- R5: The first-level interrupt is true when bit 31 of the serial control register (0x30) is 1 and (status AND mask at 0x34) is nonzero. Bit 11 of the raw-input register (0x5C) follows it in both directions, and all other bits of 0x5C read 0.
- R6: On every clock, second-level status (0x50) gains (raw input AND mask at 0x54). Its bits stay set after the input falls.
- R7: A write to 0x50 clears exactly the bits written as 1.
- R8: `irq_out` is high exactly while 0x50 is nonzero. With the enable bit and both mask bits set, a source line first high at edge k raises `irq_out` after edge k+1.
- R9: Writes to 0x5C and to the error-address register 0x40 have no effect, and 0x40 reads 0.
- R10: Reads of any offset other than 0x24, 0x28, 0x30, 0x34, 0x38, 0x40, 0x50, 0x54, 0x58 and 0x5C return 0xFFFFFFFF. Writes to such offsets change no register.
- R11: The polarity register (0x58) reads back the value written to it and has no effect on the interrupt path.
- R12: The control register (0x30) and both mask registers (0x34, 0x54) read back the full 32-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_irq | input | 17 | Serial interrupt lines, bit n is line n |
| irq_out | output | 1 | Upstream interrupt |

## Verification
The bench targets the cycle in which a source line is still high while software clears its status bit. A design that let the clear win would lose that event. It also drops the first-level level after the second level has latched it. A design whose second stage followed its input instead of holding it would drop `irq_out` too early. The bench checks two-edge latency from a line to `irq_out` exactly, which catches an extra or a missing register stage. It writes to the raw-input, error-address and unmapped offsets and then reads every register back, which exposes a decoder that aliases those writes onto real storage or returns zero in place of all ones.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam logic [7:0] OFF_IDSEL = 8'h24;
   localparam logic [7:0] OFF_RDSZ  = 8'h28;
   localparam logic [7:0] OFF_SCTL  = 8'h30;
   localparam logic [7:0] OFF_HMSK  = 8'h34;
   localparam logic [7:0] OFF_HSTS  = 8'h38;
   localparam logic [7:0] OFF_EADR  = 8'h40;
   localparam logic [7:0] OFF_MSTS  = 8'h50;
   localparam logic [7:0] OFF_MMSK  = 8'h54;
   localparam logic [7:0] OFF_MPOL  = 8'h58;
   localparam logic [7:0] OFF_MINP  = 8'h5C;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_IDSEL, SEL_RDSZ, SEL_SCTL, SEL_HMSK, SEL_HSTS,
      SEL_EADR, SEL_MSTS, SEL_MMSK, SEL_MPOL, SEL_MINP
   } reg_sel_e;
endpackage

// File: rtl/irqc_hc_stage.sv
module irqc_hc_stage #(
   parameter int DATA_W  = 32,
   parameter int NUM_SRC = 17,
   parameter int EN_BIT  = 31,
   parameter logic [DATA_W-1:0] RDSZ_RST = 32'h0200_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_ctrl,
   input  logic              wr_mask,
   input  logic              wr_stat,
   input  logic              wr_idsel,
   input  logic              wr_rdsz,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] idsel_q,
   output logic [DATA_W-1:0] rdsz_q,
   output logic              lvl_irq
);
   localparam int LOW_SRC_BIT = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_chk_src
      $error("NUM_SRC must not exceed DATA_W");
   end
   if (EN_BIT >= DATA_W) begin : g_chk_en
      $error("EN_BIT must lie inside the data word");
   end

   logic [DATA_W-1:0] src_bits;

   // Line n lands on bit DATA_W-1-n; bits below the source field stay zero.
   for (genvar b = 0; b < DATA_W; b++) begin : g_map
      if (b >= LOW_SRC_BIT) begin : g_line
         assign src_bits[b] = src_in[DATA_W-1-b];
      end else begin : g_none
         assign src_bits[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mask_q  <= '0;
         stat_q  <= '0;
         idsel_q <= '0;
         rdsz_q  <= RDSZ_RST;
      end else begin
         if (wr_ctrl)  ctrl_q  <= wdata;
         if (wr_mask)  mask_q  <= wdata;
         if (wr_idsel) idsel_q <= wdata;
         if (wr_rdsz)  rdsz_q  <= wdata;
         // a set from a live line wins over a clear in the same cycle
         stat_q <= (stat_q & ~(wr_stat ? wdata : '0)) | src_bits;
      end
   end

   assign lvl_irq = ctrl_q[EN_BIT] & (|(stat_q & mask_q));

   // R3: a live line leaves its status bit set after the edge
   a_r3_src_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_bits) |=> ((stat_q & $past(src_bits)) == $past(src_bits)));

   // R4: without a status write no bit can fall
   a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irqc_opb_stage.sv
module irqc_opb_stage #(
   parameter int DATA_W    = 32,
   parameter int CASC_BIT  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_irq,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_stat,
   input  logic              wr_mask,
   input  logic              wr_pol,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] pol_q,
   output logic [DATA_W-1:0] in_vec,
   output logic              irq_out
);
   if (CASC_BIT >= DATA_W) begin : g_chk_casc
      $error("CASC_BIT must lie inside the data word");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_in
      if (b == CASC_BIT) begin : g_casc
         assign in_vec[b] = lvl_irq;
      end else begin : g_zero
         assign in_vec[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         pol_q  <= '0;
      end else begin
         if (wr_mask) mask_q <= wdata;
         if (wr_pol)  pol_q  <= wdata;
         stat_q <= (stat_q & ~(wr_stat ? wdata : '0)) | (in_vec & mask_q);
      end
   end

   assign irq_out = |stat_q;

   // R6: masked input is accumulated into status on the next edge
   a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (|(in_vec & mask_q)) |=> ((stat_q & $past(in_vec & mask_q)) == $past(in_vec & mask_q)));

   // R8: the upstream line holds until software clears status
   a_r8_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !wr_stat) |=> irq_out);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int NUM_SRC  = 17,
   parameter int EN_BIT   = 31,
   parameter int CASC_BIT = 11,
   parameter logic [DATA_W-1:0] RDSZ_RST = 32'h0200_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_irq,
   output logic               irq_out
);
   import irqc_pkg::*;

   if (ADDR_W < 8) begin : g_chk_addr
      $error("ADDR_W must cover the 8-bit register offsets");
   end

   reg_sel_e sel;
   logic [DATA_W-1:0] h_ctrl, h_mask, h_stat, h_idsel, h_rdsz;
   logic [DATA_W-1:0] m_stat, m_mask, m_pol, m_in;
   logic              lvl_irq;

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == ADDR_W'(OFF_IDSEL))     sel = SEL_IDSEL;
      else if (bus_addr == ADDR_W'(OFF_RDSZ)) sel = SEL_RDSZ;
      else if (bus_addr == ADDR_W'(OFF_SCTL)) sel = SEL_SCTL;
      else if (bus_addr == ADDR_W'(OFF_HMSK)) sel = SEL_HMSK;
      else if (bus_addr == ADDR_W'(OFF_HSTS)) sel = SEL_HSTS;
      else if (bus_addr == ADDR_W'(OFF_EADR)) sel = SEL_EADR;
      else if (bus_addr == ADDR_W'(OFF_MSTS)) sel = SEL_MSTS;
      else if (bus_addr == ADDR_W'(OFF_MMSK)) sel = SEL_MMSK;
      else if (bus_addr == ADDR_W'(OFF_MPOL)) sel = SEL_MPOL;
      else if (bus_addr == ADDR_W'(OFF_MINP)) sel = SEL_MINP;
   end

   irqc_hc_stage #(
      .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .EN_BIT(EN_BIT), .RDSZ_RST(RDSZ_RST)
   ) hc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_in   (src_irq),
      .wdata    (bus_wdata),
      .wr_ctrl  (bus_wr && sel == SEL_SCTL),
      .wr_mask  (bus_wr && sel == SEL_HMSK),
      .wr_stat  (bus_wr && sel == SEL_HSTS),
      .wr_idsel (bus_wr && sel == SEL_IDSEL),
      .wr_rdsz  (bus_wr && sel == SEL_RDSZ),
      .ctrl_q   (h_ctrl),
      .mask_q   (h_mask),
      .stat_q   (h_stat),
      .idsel_q  (h_idsel),
      .rdsz_q   (h_rdsz),
      .lvl_irq  (lvl_irq)
   );

   irqc_opb_stage #(
      .DATA_W(DATA_W), .CASC_BIT(CASC_BIT)
   ) opb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_irq (lvl_irq),
      .wdata   (bus_wdata),
      .wr_stat (bus_wr && sel == SEL_MSTS),
      .wr_mask (bus_wr && sel == SEL_MMSK),
      .wr_pol  (bus_wr && sel == SEL_MPOL),
      .stat_q  (m_stat),
      .mask_q  (m_mask),
      .pol_q   (m_pol),
      .in_vec  (m_in),
      .irq_out (irq_out)
   );

   always_comb begin
      unique case (sel)
         SEL_IDSEL: bus_rdata = h_idsel;
         SEL_RDSZ:  bus_rdata = h_rdsz;
         SEL_SCTL:  bus_rdata = h_ctrl;
         SEL_HMSK:  bus_rdata = h_mask;
         SEL_HSTS:  bus_rdata = h_stat;
         SEL_EADR:  bus_rdata = '0;
         SEL_MSTS:  bus_rdata = m_stat;
         SEL_MMSK:  bus_rdata = m_mask;
         SEL_MPOL:  bus_rdata = m_pol;
         SEL_MINP:  bus_rdata = m_in;
         default:   bus_rdata = '1;
      endcase
   end

   // R5: the cascade bit of the raw input mirrors the first-level interrupt
   a_r5_cascade_follows: assert property (@(posedge clk) disable iff (!rst_n)
      m_in[CASC_BIT] == (h_ctrl[EN_BIT] && ((h_stat & h_mask) != '0)));

   // R10: an unmapped offset never yields anything but all ones
   a_r10_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (bus_rdata == '1));
endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0;
   logic [7:0]  b_addr = 8'h00;
   logic [31:0] b_wdata = '0;
   logic [31:0] b_rdata;
   logic [16:0] src = '0;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_cascade_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(b_rdata), .src_irq(src), .irq_out(irq_out)
   );

   // reference model built from the requirements
   logic [31:0] m_ctrl, m_mask1, m_s1, m_idsel, m_rdsz, m_s2, m_mask2, m_pol;
   logic        m_l1;

   function automatic logic [31:0] map_src(logic [16:0] s);
      logic [31:0] r = '0;
      for (int i = 0; i < 17; i++) r[31-i] = s[i];
      return r;
   endfunction

   assign m_l1 = m_ctrl[31] && ((m_s1 & m_mask1) != 32'h0);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= '0; m_mask1 <= '0; m_s1 <= '0; m_idsel <= '0;
         m_rdsz <= 32'h0200_0000; m_s2 <= '0; m_mask2 <= '0; m_pol <= '0;
      end else begin
         if (b_wr) begin
            case (b_addr)
               8'h24: m_idsel <= b_wdata;
               8'h28: m_rdsz  <= b_wdata;
               8'h30: m_ctrl  <= b_wdata;
               8'h34: m_mask1 <= b_wdata;
               8'h54: m_mask2 <= b_wdata;
               8'h58: m_pol   <= b_wdata;
               default: ;
            endcase
         end
         m_s1 <= (m_s1 & ~((b_wr && b_addr == 8'h38) ? b_wdata : 32'h0)) | map_src(src);
         m_s2 <= (m_s2 & ~((b_wr && b_addr == 8'h50) ? b_wdata : 32'h0))
                 | ((m_l1 ? 32'h0000_0800 : 32'h0) & m_mask2);
      end
   end

   function automatic logic [31:0] exp_read(logic [7:0] a);
      case (a)
         8'h24: return m_idsel;
         8'h28: return m_rdsz;
         8'h30: return m_ctrl;
         8'h34: return m_mask1;
         8'h38: return m_s1;
         8'h40: return 32'h0;
         8'h50: return m_s2;
         8'h54: return m_mask2;
         8'h58: return m_pol;
         8'h5C: return m_l1 ? 32'h0000_0800 : 32'h0;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      b_wr = 1'b1; b_addr = a; b_wdata = d;
      @(negedge clk);
      b_wr = 1'b0;
   endtask

   // sample a read half a cycle away from the edge
   task automatic rd_chk(string req, logic [7:0] a);
      b_addr = a;
      #1;
      check(req, b_rdata, exp_read(a));
   endtask

   task automatic rd_lit(string req, logic [7:0] a, logic [31:0] e);
      b_addr = a;
      #1;
      check(req, b_rdata, e);
   endtask

   task automatic all_regs(string req);
      logic [7:0] list [10] = '{8'h24, 8'h28, 8'h30, 8'h34, 8'h38,
                                8'h40, 8'h50, 8'h54, 8'h58, 8'h5C};
      foreach (list[i]) rd_chk(req, list[i]);
      check(req, {31'h0, irq_out}, {31'h0, (m_s2 != 0)});
   endtask

   task automatic set_src(logic [16:0] s);
      @(negedge clk);
      src = s;
   endtask

   initial begin
      logic [7:0] pick [14] = '{8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h40, 8'h50,
                                8'h54, 8'h58, 8'h5C, 8'h00, 8'h3C, 8'h31, 8'hFC};
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset values
      rd_lit("R1", 8'h28, 32'h0200_0000);
      rd_lit("R1", 8'h38, 32'h0);
      rd_lit("R1", 8'h50, 32'h0);
      rd_lit("R1", 8'h30, 32'h0);
      check("R1", {31'h0, irq_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 storage registers
      wr(8'h24, 32'hA5A5_1234);
      wr(8'h28, 32'h0000_0001);
      rd_lit("R2", 8'h24, 32'hA5A5_1234);
      rd_lit("R2", 8'h28, 32'h0000_0001);

      // R12 control and masks
      wr(8'h30, 32'h8000_0000);
      wr(8'h34, 32'hFFFF_8000);
      wr(8'h54, 32'h0000_0800);
      rd_lit("R12", 8'h30, 32'h8000_0000);
      rd_lit("R12", 8'h34, 32'hFFFF_8000);
      rd_lit("R12", 8'h54, 32'h0000_0800);

      // R8 latency: line 3 high before edge k
      @(negedge clk);
      src = 17'h0_0008;
      @(negedge clk);
      check("R8 after edge k", {31'h0, irq_out}, 32'h0);
      rd_lit("R5", 8'h5C, 32'h0000_0800);
      @(negedge clk);
      check("R8 after edge k+1", {31'h0, irq_out}, 32'h1);
      src = '0;
      repeat (3) @(negedge clk);
      rd_lit("R3", 8'h38, 32'h1000_0000);

      // R5 drop, R6 sticky second level
      wr(8'h38, 32'h1000_0000);
      rd_lit("R5", 8'h5C, 32'h0);
      rd_lit("R6", 8'h50, 32'h0000_0800);
      check("R6", {31'h0, irq_out}, 32'h1);
      // R7 clear second level
      wr(8'h50, 32'h0000_0800);
      rd_lit("R7", 8'h50, 32'h0);
      check("R7", {31'h0, irq_out}, 32'h0);

      // R4 set wins over clear while the line is high
      set_src(17'h0_0001);
      wr(8'h38, 32'h8000_0000);
      rd_lit("R4", 8'h38, 32'h8000_0000);
      set_src(17'h1_0002);
      wr(8'h38, 32'h8000_0000);
      set_src('0);
      wr(8'h38, 32'h4000_0000);
      rd_lit("R4", 8'h38, 32'h0000_8000);

      // R5 enable gating
      wr(8'h30, 32'h0);
      wr(8'h50, 32'hFFFF_FFFF);
      rd_lit("R5", 8'h5C, 32'h0);
      @(negedge clk);
      check("R5", {31'h0, irq_out}, 32'h0);

      // R9 ignored writes
      wr(8'h5C, 32'hFFFF_FFFF);
      wr(8'h40, 32'hFFFF_FFFF);
      rd_lit("R9", 8'h40, 32'h0);
      rd_lit("R9", 8'h5C, 32'h0);
      all_regs("R9");

      // R10 unmapped offsets
      rd_lit("R10", 8'h00, 32'hFFFF_FFFF);
      rd_lit("R10", 8'h3C, 32'hFFFF_FFFF);
      rd_lit("R10", 8'h60, 32'hFFFF_FFFF);
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'h4C, 32'hFFFF_FFFF);
      all_regs("R10");

      // R11 polarity stored, no effect
      wr(8'h58, 32'hFFFF_FFFF);
      rd_lit("R11", 8'h58, 32'hFFFF_FFFF);
      wr(8'h30, 32'h8000_0000);
      @(negedge clk);
      check("R11", {31'h0, irq_out}, 32'h1);
      all_regs("R11");

      // random phase against the model
      for (int it = 0; it < 3000; it++) begin
         logic [7:0] a;
         logic [31:0] d;
         @(negedge clk);
         src = 17'($urandom & $urandom & $urandom);
         a = pick[$urandom_range(0, 13)];
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d = d | 32'h8000_0800;
         if ($urandom_range(0, 1) == 0) wr(a, d);
         rd_chk("R3/R4/R6 random", pick[$urandom_range(0, 13)]);
         check("R8 random", {31'h0, irq_out}, {31'h0, (m_s2 != 0)});
      end
      src = '0;
      @(negedge clk);
      all_regs("R5/R7 final");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule